// File: doc/BRIEF.md
# Cycle-Countdown Interrupt Timer with Selectable Span

This block raises an interrupt request after a programmed number of processor cycles. Software builds a 16-bit reload value in four 4-bit pieces, copies it into a down-counter with a single write, and then starts the count with a control write. The control write also chooses how much of the counter is watched. The request can fire when the whole counter runs out. It can also fire when the top 4, top 8 or top 12 bits change, which gives a short timer that rolls over at a 4096-, 256- or 16-cycle boundary.

The counter steps once per asserted `cpu_tick`. When the watched condition occurs, the block does three things in the same edge: it raises `irq_o`, it forces the counter to zero and it turns itself off. The request stays high until software writes the control register again or reset is applied. Only the low nibble of the processor data bus is used, and it is brought in on `wr_data`.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset `irq_o` is low, the counter and the reload latch both hold 0xFFFF, the enable bit is 0 and the mode is 0.
- R2: A write to address 0xE000+k (k = 0..3) places `wr_data` into latch bits [4k+3:4k]. All other latch bits keep their values.
- R3: A write to 0xF000 copies the whole latch into the counter. If a tick arrives in the same cycle, the copy wins and the counter is not decremented.
- R4: A write to 0xF001 sets enable from `wr_data[0]` and mode from `wr_data[3:1]`, and it clears `irq_o` on the next edge. This clear wins over a firing that happens in the same cycle.
- R5: The counter drops by exactly one for each cycle with `cpu_tick` high, and only while enable is 1 and the counter is nonzero. Otherwise it holds its value and no new request is raised.
- R6: In mode 0 the request fires on the tick that brings the counter to zero.
- R7: In mode 1 the request fires on the tick that changes counter bits [15:12].
- R8: In modes 2 and 3 the request fires on the tick that changes counter bits [15:8].
- R9: In modes 4 to 7 the request fires on the tick that changes counter bits [15:4].
- R10: On a firing, `irq_o` rises after that edge, the counter becomes 0 and enable is cleared.
- R11: Once high, `irq_o` stays high until a write to 0xF001 or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Processor write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 4 | Low nibble of the write data |
| cpu_tick | input | 1 | High for one clock per processor cycle to be counted |
| irq_o | output | 1 | Interrupt request, high until acknowledged |

## Verification
The hardest states to reach are the ones that only show up indirectly: the counter left at zero by a firing, and enable cleared by hardware rather than by software. Neither can be read at the ports. To expose them, the stimulus reloads the counter after a firing and ticks it without writing the control register. Only then does it acknowledge the request and re-enable the timer. The length of the next countdown shows whether ticks were lost while the timer should have been idle. Same-cycle collisions are placed deliberately: a reload together with a tick, and a control write on the exact tick that would fire. Mode 1 is also started from a value below 0x1000, so the counter drains to zero without ever firing.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

    localparam int MODE_W = 3;
    localparam int EN_BIT = 0;

    localparam logic [15:0] LATCH_BASE_DEF = 16'hE000;
    localparam logic [15:0] RELOAD_ADDR_DEF = 16'hF000;
    localparam logic [15:0] CTRL_ADDR_DEF = 16'hF001;

    // Portion of the counter that is watched for a firing
    typedef enum logic [1:0] {
        SPAN_ZERO = 2'd0,
        SPAN_TOP1 = 2'd1,
        SPAN_TOP2 = 2'd2,
        SPAN_TOP3 = 2'd3
    } span_e;

    function automatic span_e mode_to_span(input logic [MODE_W-1:0] mode);
        span_e s;
        case (mode)
            3'd0:       s = SPAN_ZERO;
            3'd1:       s = SPAN_TOP1;
            3'd2, 3'd3: s = SPAN_TOP2;
            default:    s = SPAN_TOP3;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cyc_wr_decode.sv
module cyc_wr_decode #(
    parameter int          ADDR_W      = 16,
    parameter int          NIBBLES     = 4,
    parameter logic [15:0] LATCH_BASE  = 16'hE000,
    parameter logic [15:0] RELOAD_ADDR = 16'hF000,
    parameter logic [15:0] CTRL_ADDR   = 16'hF001
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [NIBBLES-1:0] nib_we,
    output logic              reload_we,
    output logic              ctrl_we
);

    for (genvar i = 0; i < NIBBLES; i++) begin : g_nib
        localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(LATCH_BASE) + ADDR_W'(i);
        assign nib_we[i] = wr_en && (wr_addr == SLOT);
    end

    assign reload_we = wr_en && (wr_addr == ADDR_W'(RELOAD_ADDR));
    assign ctrl_we   = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

endmodule

// File: rtl/cyc_reload_latch.sv
module cyc_reload_latch #(
    parameter int CNT_W = 16,
    parameter int NIB_W = 4,
    localparam int NIBBLES = CNT_W / NIB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NIBBLES-1:0] nib_we,
    input  logic [NIB_W-1:0]   nib_data,
    output logic [CNT_W-1:0]   latch_q
);

    logic [CNT_W-1:0] latch_d;

    always_comb begin
        latch_d = latch_q;
        for (int i = 0; i < NIBBLES; i++) begin
            if (nib_we[i]) begin
                latch_d[i*NIB_W +: NIB_W] = nib_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '1;
        end else begin
            latch_q <= latch_d;
        end
    end

endmodule

// File: rtl/cyc_fire_detect.sv
module cyc_fire_detect
    import cyc_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NIB_W = 4
) (
    input  logic [CNT_W-1:0]  cnt_old,
    input  logic [CNT_W-1:0]  cnt_new,
    input  logic [MODE_W-1:0] mode,
    output logic              hit
);

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] MASK_TOP1 = ~(ALL_ONES >> NIB_W);
    localparam logic [CNT_W-1:0] MASK_TOP2 = ~(ALL_ONES >> (2 * NIB_W));
    localparam logic [CNT_W-1:0] MASK_TOP3 = ~(ALL_ONES >> (3 * NIB_W));

    logic [CNT_W-1:0] flipped;

    always_comb begin
        flipped = cnt_old ^ cnt_new;
        case (mode_to_span(mode))
            SPAN_ZERO: hit = (cnt_new == '0);
            SPAN_TOP1: hit = |(flipped & MASK_TOP1);
            SPAN_TOP2: hit = |(flipped & MASK_TOP2);
            default:   hit = |(flipped & MASK_TOP3);
        endcase
    end

endmodule

// File: rtl/cyc_count_core.sv
module cyc_count_core
    import cyc_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload_we,
    input  logic             ctrl_we,
    input  logic [NIB_W-1:0] ctrl_data,
    input  logic [CNT_W-1:0] latch_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             en_q,
    output logic             irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              en;
        logic [MODE_W-1:0] mode;
        logic              irq;
    } core_t;

    core_t st_d, st_q;
    logic [CNT_W-1:0] cnt_dec;
    logic step_ok, span_hit, fire;

    assign cnt_dec = st_q.cnt - CNT_W'(1);

    cyc_fire_detect #(
        .CNT_W(CNT_W),
        .NIB_W(NIB_W)
    ) fire_i (
        .cnt_old(st_q.cnt),
        .cnt_new(cnt_dec),
        .mode   (st_q.mode),
        .hit    (span_hit)
    );

    always_comb begin
        st_d    = st_q;
        step_ok = tick && st_q.en && (st_q.cnt != '0) && !reload_we;
        fire    = step_ok && span_hit;

        if (reload_we) begin
            st_d.cnt = latch_q;
        end else if (step_ok) begin
            st_d.cnt = fire ? '0 : cnt_dec;
        end

        if (fire) begin
            st_d.en  = 1'b0;
            st_d.irq = 1'b1;
        end

        if (ctrl_we) begin
            st_d.en   = ctrl_data[EN_BIT];
            st_d.mode = ctrl_data[MODE_W:1];
            st_d.irq  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '1;
            st_q.en   <= 1'b0;
            st_q.mode <= '0;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;
    assign en_q  = st_q.en;
    assign irq_o = st_q.irq;

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
    import cyc_timer_pkg::*;
#(
    parameter int          CNT_W       = 16,
    parameter int          NIB_W       = 4,
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] LATCH_BASE  = LATCH_BASE_DEF,
    parameter logic [15:0] RELOAD_ADDR = RELOAD_ADDR_DEF,
    parameter logic [15:0] CTRL_ADDR   = CTRL_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NIB_W-1:0]  wr_data,
    input  logic              cpu_tick,
    output logic              irq_o
);

    localparam int NIBBLES = CNT_W / NIB_W;

    logic [NIBBLES-1:0] nib_we;
    logic               reload_we;
    logic               ctrl_we;
    logic [CNT_W-1:0]   latch_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               en_q;

    cyc_wr_decode #(
        .ADDR_W     (ADDR_W),
        .NIBBLES    (NIBBLES),
        .LATCH_BASE (LATCH_BASE),
        .RELOAD_ADDR(RELOAD_ADDR),
        .CTRL_ADDR  (CTRL_ADDR)
    ) dec_i (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .nib_we   (nib_we),
        .reload_we(reload_we),
        .ctrl_we  (ctrl_we)
    );

    cyc_reload_latch #(
        .CNT_W(CNT_W),
        .NIB_W(NIB_W)
    ) latch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .nib_we  (nib_we),
        .nib_data(wr_data),
        .latch_q (latch_q)
    );

    cyc_count_core #(
        .CNT_W(CNT_W),
        .NIB_W(NIB_W)
    ) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (cpu_tick),
        .reload_we(reload_we),
        .ctrl_we  (ctrl_we),
        .ctrl_data(wr_data),
        .latch_q  (latch_q),
        .cnt_q    (cnt_q),
        .en_q     (en_q),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
    parameter int          CNT_W       = 16,
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] RELOAD_ADDR = 16'hF000,
    parameter logic [15:0] CTRL_ADDR   = 16'hF001
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              irq_o,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              en_q,
    input logic [CNT_W-1:0]  latch_q
);

    logic is_reload, is_ctrl;
    assign is_reload = wr_en && (wr_addr == ADDR_W'(RELOAD_ADDR));
    assign is_ctrl   = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && cnt_q == '1 && latch_q == '1 && !en_q));

    // R3
    reload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_reload |=> (cnt_q == $past(latch_q)));

    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ctrl |=> !irq_o);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !is_reload) |=> $stable(cnt_q));

    // R5
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !is_reload) |=> (cnt_q == '0));

    // R10
    fire_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (cnt_q == '0 && !en_q));

    // R11
    sticky_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !is_ctrl) |=> irq_o);

endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(
    .CNT_W      (CNT_W),
    .ADDR_W     (ADDR_W),
    .RELOAD_ADDR(RELOAD_ADDR),
    .CTRL_ADDR  (CTRL_ADDR)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .irq_o  (irq_o),
    .cnt_q  (cnt_q),
    .en_q   (en_q),
    .latch_q(latch_q)
);

// File: tb/cyc_irq_timer_tb_top.sv
`timescale 1ns/1ps
module cyc_irq_timer_tb_top;

    localparam real CLK_PER = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [3:0]  wr_data = '0;
    logic        cpu_tick = 1'b0;
    logic        irq_o;

    always #(CLK_PER / 2.0) clk = ~clk;

    cyc_irq_timer dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cpu_tick(cpu_tick),
        .irq_o   (irq_o)
    );

    typedef struct {
        logic  irq;
        string req;
    } exp_t;

    exp_t  exp_q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // Reference state built from the requirements
    logic [15:0] m_latch, m_cnt;
    logic        m_en, m_irq;
    logic [2:0]  m_mode;

    task automatic model_reset();
        m_latch = 16'hFFFF; m_cnt = 16'hFFFF;
        m_en = 1'b0; m_irq = 1'b0; m_mode = 3'd0;
    endtask

    task automatic model_step(input logic w, input logic [15:0] a,
                              input logic [3:0] d, input logic t);
        logic        rld, ctl, dec, hit, fire;
        logic [15:0] nc, chg;
        rld = w && a == 16'hF000;
        ctl = w && a == 16'hF001;
        dec = t && m_en && m_cnt != 16'h0 && !rld;
        nc  = m_cnt - 16'h1;
        chg = nc ^ m_cnt;
        case (m_mode)
            3'd0:       hit = (nc == 16'h0);
            3'd1:       hit = |chg[15:12];
            3'd2, 3'd3: hit = |chg[15:8];
            default:    hit = |chg[15:4];
        endcase
        fire = dec && hit;
        if (rld) m_cnt = m_latch;
        else if (dec) m_cnt = fire ? 16'h0 : nc;
        if (fire) begin m_en = 1'b0; m_irq = 1'b1; end
        if (ctl) begin m_en = d[0]; m_mode = d[3:1]; m_irq = 1'b0; end
        for (int k = 0; k < 4; k++)
            if (w && a == 16'hE000 + 16'(k)) m_latch[k*4 +: 4] = d;
    endtask

    // Driver: one clock per call, expected output queued after the edge
    task automatic cyc(input logic w, input logic [15:0] a,
                       input logic [3:0] d, input logic t);
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; cpu_tick = t;
        @(posedge clk);
        model_step(w, a, d, t);
        exp_q.push_back(exp_t'{irq: m_irq, req: cur_req});
    endtask

    task automatic wr(input logic [15:0] a, input logic [3:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic run(input int n, input logic t);
        for (int i = 0; i < n; i++) cyc(1'b0, 16'h0000, 4'h0, t);
    endtask

    task automatic set_latch(input logic [15:0] v);
        for (int k = 0; k < 4; k++) wr(16'hE000 + 16'(k), v[k*4 +: 4]);
    endtask

    task automatic print_summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    // Monitor: compares each produced output with the queued expectation
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (irq_o !== e.irq) begin
                n_errors++;
                $display("FAIL %s: irq_o actual=%b expected=%b at %0t",
                         e.req, irq_o, e.irq, $time);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            print_summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        n_checks++;
        if (irq_o !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: irq_o in reset actual=%b expected=0", irq_o);
        end
        rst_n = 1'b1;

        // R1: quiet after reset, counter starts at 0xFFFF (mode 0 needs 65535 ticks)
        cur_req = "R1";
        run(3, 1'b1);
        wr(16'hF001, 4'h1);
        run(65540, 1'b1);

        // R11: request holds without acknowledge
        cur_req = "R11";
        run(6, 1'b1);
        wr(16'hE000, 4'h7);
        run(3, 1'b0);

        // R4: acknowledge
        cur_req = "R4";
        wr(16'hF001, 4'h0);
        run(3, 1'b1);

        // R2: nibble writes, partial rewrite keeps other nibbles -> 0x0035
        cur_req = "R2";
        set_latch(16'h0025);
        wr(16'hE001, 4'h3);
        wr(16'hF000, 4'h0);
        wr(16'hF001, 4'h1);
        run(60, 1'b1);

        // R10: counter zeroed after firing, re-enable gives nothing
        cur_req = "R10";
        wr(16'hF001, 4'h1);
        run(20, 1'b1);
        // R10: enable auto-cleared; reload then tick while nobody re-enabled
        set_latch(16'h0005);
        wr(16'hF000, 4'h0);
        run(10, 1'b1);
        wr(16'hF000, 4'h0);
        run(10, 1'b1);
        wr(16'hF001, 4'h1);
        run(10, 1'b1);

        // R5: gapped ticks, and disabled hold
        cur_req = "R5";
        wr(16'hF001, 4'h0);
        wr(16'hF000, 4'h0);
        run(8, 1'b1);
        wr(16'hF001, 4'h1);
        for (int i = 0; i < 16; i++) cyc(1'b0, 16'h0000, 4'h0, i[0]);

        // R3: reload together with a tick is not decremented
        cur_req = "R3";
        wr(16'hF001, 4'h1);
        cyc(1'b1, 16'hF000, 4'h0, 1'b1);
        run(8, 1'b1);

        // R6: mode 0 from 3
        cur_req = "R6";
        wr(16'hF001, 4'h0);
        set_latch(16'h0003);
        wr(16'hF000, 4'h0);
        wr(16'hF001, 4'h1);
        run(6, 1'b1);

        // R7: mode 1, 0x1003 fires on 4th tick; 0x0005 drains without firing
        cur_req = "R7";
        wr(16'hF001, 4'h0);
        set_latch(16'h1003);
        wr(16'hF000, 4'h0);
        wr(16'hF001, 4'h3);
        run(8, 1'b1);
        wr(16'hF001, 4'h0);
        set_latch(16'h0005);
        wr(16'hF000, 4'h0);
        wr(16'hF001, 4'h3);
        run(10, 1'b1);
        cur_req = "R5";
        wr(16'hF001, 4'h1);
        run(5, 1'b1);

        // R8: modes 2 and 3 from 0x0105 fire on 6th tick
        cur_req = "R8";
        for (int m = 2; m <= 3; m++) begin
            wr(16'hF001, 4'h0);
            set_latch(16'h0105);
            wr(16'hF000, 4'h0);
            wr(16'hF001, 4'(m * 2 + 1));
            run(9, 1'b1);
        end

        // R9: modes 4..7 from 0x0013 fire on 4th tick
        cur_req = "R9";
        for (int m = 4; m <= 7; m++) begin
            wr(16'hF001, 4'h0);
            set_latch(16'h0013);
            wr(16'hF000, 4'h0);
            wr(16'hF001, 4'(m * 2 + 1));
            run(7, 1'b1);
        end

        // R4: control write on the firing tick wins over the firing
        cur_req = "R4";
        wr(16'hF001, 4'h0);
        set_latch(16'h0003);
        wr(16'hF000, 4'h0);
        wr(16'hF001, 4'h1);
        run(2, 1'b1);
        cyc(1'b1, 16'hF001, 4'h1, 1'b1);
        run(6, 1'b1);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        print_summary();
        $finish;
    end

endmodule